// File: doc/BRIEF.md
# Band Table-Lookup Engine

The engine searches a table held in decimal word memory for the first entry whose magnitude is at least that of a search argument. A search is launched with a four-digit BCD data address and a ten-digit BCD argument. The walk starts at the first word of the 50-word band that holds that address and moves upward one address per clock. It runs on into later bands when needed. The last two words of every band are reserved: they are stepped over without being read.

When an entry qualifies, the engine returns the lower accumulator word with one four-digit field replaced. That field is digits 8 to 5, counting from 1 at the least significant digit. It receives the launch address plus the number of addresses stepped. The other digits and the sign pass through unchanged. If the walk runs off the end of memory, the search ends with an error and the accumulator is left alone. Either way, the engine reports how many addresses it stepped and an execution length in machine steps.

The control is a four-state machine. `S_IDLE` waits for `start` and moves to `S_SCAN`. `S_SCAN` handles one address per cycle. It goes to `S_WRITE` on a qualifying entry and to `S_FAIL` when the address reaches the memory size. Otherwise it stays in `S_SCAN`, which covers both a reserved skip and a miss. `S_WRITE` and `S_FAIL` each last one cycle and return to `S_IDLE`.

Top module: `tlu_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `err`, `rd_en` and `acc_lo_we` are all 0.
- R2: The walk starts at the binary value of `start_addr` rounded down to a multiple of 50 and visits ascending addresses, one per cycle. It continues across band boundaries. `rd_addr` is the binary word address.
- R3: Addresses whose value modulo 50 is 48 or 49 are never read (`rd_en` stays 0) and never compared.
- R4: An entry qualifies when its ten BCD digits, read as an unsigned decimal magnitude, are greater than or equal to `dist_mag`. The first qualifying address ends the walk.
- R5: On success, `acc_lo_we` and `done` are 1 for one cycle. In that cycle `acc_lo_out[31:16]` holds the BCD of (launch address + addresses stepped) mod 10000. All other bits of `acc_lo_out` equal `acc_lo_in`, and `acc_lo_neg_out` equals `acc_lo_neg_in`.
- R6: If the address to visit is not below MEM_WORDS (2000 by default), the search ends with `done` and `err` both 1 and `acc_lo_we` 0. No address at or above MEM_WORDS is read.
- R7: From the `done` cycle until the next launch, `entry_count` equals the number of addresses stepped before the walk ended, with skipped words included. `exec_len` equals 6 + `entry_count` + 1 when `even_time` was 1 at launch, and 6 + `entry_count` otherwise.
- R8: `busy` is 1 from the cycle after an accepted `start` through the `done` cycle. `start` pulses while busy are ignored.
- R9: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| start_addr | input | 16 | Four-digit BCD data address |
| dist_mag | input | 40 | Ten-digit BCD search argument magnitude |
| even_time | input | 1 | Launch falls on an even word time |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 11 | Binary word address to read |
| rd_mag | input | 40 | Ten-digit BCD magnitude of the addressed word, same cycle |
| acc_lo_in | input | 40 | Current lower accumulator digits |
| acc_lo_neg_in | input | 1 | Current accumulator sign |
| acc_lo_out | output | 40 | Lower accumulator with the address field replaced |
| acc_lo_neg_out | output | 1 | Accumulator sign, passed through |
| acc_lo_we | output | 1 | Accumulator write strobe |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished (success or error) |
| err | output | 1 | Search ran past the end of memory |
| entry_count | output | 14 | Addresses stepped |
| exec_len | output | 11 | Execution length in machine steps |

## Verification
Several directed tables are used:
- a band whose first word already qualifies, which shows the result counts from the launch address and not from the band start;
- a band whose ordinary words are all too small while its reserved words would qualify, which shows reserved words are skipped and the walk crosses into the next band;
- an entry exactly equal to the argument, set against one smaller only in its lowest digit or only in its top digit, which separates greater-or-equal from greater-than and confirms the most significant digit dominates.

Launches in the last band and beyond memory separate the error path from a late hit. Random tables and arguments with both word-time parities then exercise walk lengths and field insertion against a bench search model.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

    localparam int ADDR_DIGITS   = 4;
    localparam int ADDR_BITS     = 4 * ADDR_DIGITS;
    localparam int ADDR_BIN_BITS = $clog2(10 ** ADDR_DIGITS);

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SCAN  = 2'd1,
        S_WRITE = 2'd2,
        S_FAIL  = 2'd3
    } tlu_state_e;

    // BCD address digits to binary word number
    function automatic logic [ADDR_BIN_BITS-1:0] bcd_to_bin(input logic [ADDR_BITS-1:0] b);
        int v;
        v = 0;
        for (int i = ADDR_DIGITS - 1; i >= 0; i--) begin
            v = v * 10 + int'(b[4*i +: 4]);
        end
        return ADDR_BIN_BITS'(v);
    endfunction

    // binary word number to BCD, wrapping at the digit count
    function automatic logic [ADDR_BITS-1:0] bin_to_bcd(input int v);
        logic [ADDR_BITS-1:0] r;
        int t;
        t = v % (10 ** ADDR_DIGITS);
        for (int i = 0; i < ADDR_DIGITS; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/tlu_mag_cmp.sv
module tlu_mag_cmp #(
    parameter int DIGITS = 10
) (
    input  logic [4*DIGITS-1:0] entry,
    input  logic [4*DIGITS-1:0] arg,
    output logic                ge
);

    // chain from the least significant digit; a higher digit that differs
    // overrides every decision made below it
    logic [DIGITS:0] ge_chain;

    assign ge_chain[0] = 1'b1;

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        logic [3:0] e_d;
        logic [3:0] a_d;
        assign e_d = entry[4*d +: 4];
        assign a_d = arg[4*d +: 4];
        assign ge_chain[d+1] = (e_d != a_d) ? (e_d > a_d) : ge_chain[d];
    end

    assign ge = ge_chain[DIGITS];

endmodule

// File: rtl/tlu_addr_walk.sv
module tlu_addr_walk #(
    parameter int MEM_WORDS  = 2000,
    parameter int BAND_WORDS = 50,
    parameter int RSV_WORDS  = 2,
    parameter int CBITS      = 14,
    parameter int AW         = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CBITS-1:0] da,
    output logic [AW-1:0]    cur_addr,
    output logic [CBITS-1:0] stepped,
    output logic             reserved,
    output logic             past_end
);

    localparam int PBITS = $clog2(BAND_WORDS);

    logic [CBITS-1:0] cur;
    logic [PBITS-1:0] pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            pos     <= '0;
            stepped <= '0;
        end else if (load) begin
            cur     <= da - (da % CBITS'(BAND_WORDS));
            pos     <= '0;
            stepped <= '0;
        end else if (step) begin
            cur     <= cur + CBITS'(1);
            pos     <= (pos == PBITS'(BAND_WORDS - 1)) ? '0 : pos + PBITS'(1);
            stepped <= stepped + CBITS'(1);
        end
    end

    assign cur_addr = cur[AW-1:0];
    assign reserved = (pos >= PBITS'(BAND_WORDS - RSV_WORDS));
    assign past_end = (cur >= CBITS'(MEM_WORDS));

endmodule

// File: rtl/tlu_field_merge.sv
module tlu_field_merge #(
    parameter int DIGITS       = 10,
    parameter int FIELD_LSD    = 4,
    parameter int FIELD_DIGITS = 4
) (
    input  logic [4*DIGITS-1:0]       word_in,
    input  logic [4*FIELD_DIGITS-1:0] field,
    output logic [4*DIGITS-1:0]       word_out
);

    localparam int W  = 4 * DIGITS;
    localparam int FW = 4 * FIELD_DIGITS;
    localparam logic [W-1:0] FMASK = {{(W-FW){1'b0}}, {FW{1'b1}}} << (4 * FIELD_LSD);

    logic [W-1:0] field_pos;

    assign field_pos = {{(W-FW){1'b0}}, field} << (4 * FIELD_LSD);
    assign word_out  = (word_in & ~FMASK) | (field_pos & FMASK);

endmodule

// File: rtl/tlu_engine.sv
module tlu_engine
    import tlu_pkg::*;
#(
    parameter int MEM_WORDS  = 2000,
    parameter int BAND_WORDS = 50,
    parameter int RSV_WORDS  = 2,
    parameter int DIGITS     = 10,
    parameter int FIELD_LSD  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [ADDR_BITS-1:0]            start_addr,
    input  logic [4*DIGITS-1:0]             dist_mag,
    input  logic                            even_time,
    output logic                            rd_en,
    output logic [$clog2(MEM_WORDS)-1:0]    rd_addr,
    input  logic [4*DIGITS-1:0]             rd_mag,
    input  logic [4*DIGITS-1:0]             acc_lo_in,
    input  logic                            acc_lo_neg_in,
    output logic [4*DIGITS-1:0]             acc_lo_out,
    output logic                            acc_lo_neg_out,
    output logic                            acc_lo_we,
    output logic                            busy,
    output logic                            done,
    output logic                            err,
    output logic [ADDR_BIN_BITS-1:0]        entry_count,
    output logic [$clog2(MEM_WORDS+8)-1:0]  exec_len
);

    localparam int AW        = $clog2(MEM_WORDS);
    localparam int LW        = $clog2(MEM_WORDS + 8);
    localparam int BASE_LEN  = 6;

    tlu_state_e state, nxt;

    logic [4*DIGITS-1:0]      arg_q;
    logic [ADDR_BIN_BITS-1:0] da_q;
    logic                     even_q;

    logic                     launch;
    logic                     step;
    logic                     hit;
    logic                     reserved;
    logic                     past_end;
    logic [ADDR_BIN_BITS-1:0] stepped;
    logic [ADDR_BITS-1:0]     result_bcd;

    assign launch = (state == S_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_SCAN;
            S_SCAN: begin
                if (past_end) begin
                    nxt = S_FAIL;
                end else if (!reserved && hit) begin
                    nxt = S_WRITE;
                end
            end
            S_WRITE: nxt = S_IDLE;
            S_FAIL:  nxt = S_IDLE;
        endcase
    end

    // launch operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q  <= '0;
            da_q   <= '0;
            even_q <= 1'b0;
        end else if (launch) begin
            arg_q  <= dist_mag;
            da_q   <= bcd_to_bin(start_addr);
            even_q <= even_time;
        end
    end

    assign step = (state == S_SCAN) && !past_end && (reserved || !hit);

    tlu_addr_walk #(
        .MEM_WORDS  (MEM_WORDS),
        .BAND_WORDS (BAND_WORDS),
        .RSV_WORDS  (RSV_WORDS),
        .CBITS      (ADDR_BIN_BITS),
        .AW         (AW)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .step     (step),
        .da       (bcd_to_bin(start_addr)),
        .cur_addr (rd_addr),
        .stepped  (stepped),
        .reserved (reserved),
        .past_end (past_end)
    );

    tlu_mag_cmp #(
        .DIGITS (DIGITS)
    ) u_cmp (
        .entry (rd_mag),
        .arg   (arg_q),
        .ge    (hit)
    );

    assign result_bcd = bin_to_bcd(int'(da_q) + int'(stepped));

    tlu_field_merge #(
        .DIGITS       (DIGITS),
        .FIELD_LSD    (FIELD_LSD),
        .FIELD_DIGITS (ADDR_DIGITS)
    ) u_merge (
        .word_in  (acc_lo_in),
        .field    (result_bcd),
        .word_out (acc_lo_out)
    );

    // outputs
    always_comb begin
        rd_en          = (state == S_SCAN) && !past_end && !reserved;
        acc_lo_we      = (state == S_WRITE);
        done           = (state == S_WRITE) || (state == S_FAIL);
        err            = (state == S_FAIL);
        busy           = (state != S_IDLE);
        acc_lo_neg_out = acc_lo_neg_in;
        entry_count    = stepped;
        exec_len       = LW'(BASE_LEN) + LW'(stepped) + LW'(even_q);
    end

endmodule

// File: rtl/tlu_engine_chk.sv
module tlu_engine_chk #(
    parameter int MEM_WORDS  = 2000,
    parameter int BAND_WORDS = 50,
    parameter int RSV_WORDS  = 2,
    parameter int DIGITS     = 10,
    parameter int FIELD_LSD  = 4,
    parameter int FDIG       = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start,
    input logic                         busy,
    input logic                         done,
    input logic                         err,
    input logic                         rd_en,
    input logic [$clog2(MEM_WORDS)-1:0] rd_addr,
    input logic [4*DIGITS-1:0]          acc_lo_in,
    input logic                         acc_lo_neg_in,
    input logic [4*DIGITS-1:0]          acc_lo_out,
    input logic                         acc_lo_neg_out,
    input logic                         acc_lo_we
);

    localparam int LO_W = 4 * FIELD_LSD;
    localparam int HI_L = 4 * (FIELD_LSD + FDIG);

    // R3: reserved band words are never read
    a_r3_no_reserved_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ((int'(rd_addr) % BAND_WORDS) < (BAND_WORDS - RSV_WORDS)));

    // R6: no read at or above the memory size
    a_r6_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < MEM_WORDS));

    // R6: an error never writes the accumulator
    a_r6_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !acc_lo_we);

    // R5: write only with completion, outside digits and sign untouched
    a_r5_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        acc_lo_we |-> done);

    a_r5_keep_other_digits: assert property (@(posedge clk) disable iff (!rst_n)
        acc_lo_we |-> (acc_lo_out[LO_W-1:0] == acc_lo_in[LO_W-1:0]) &&
                      (acc_lo_out[4*DIGITS-1:HI_L] == acc_lo_in[4*DIGITS-1:HI_L]) &&
                      (acc_lo_neg_out == acc_lo_neg_in));

    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an accepted launch raises busy
    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8: done only while busy
    a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind tlu_engine tlu_engine_chk #(
    .MEM_WORDS  (MEM_WORDS),
    .BAND_WORDS (BAND_WORDS),
    .RSV_WORDS  (RSV_WORDS),
    .DIGITS     (DIGITS),
    .FIELD_LSD  (FIELD_LSD),
    .FDIG       (tlu_pkg::ADDR_DIGITS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .busy           (busy),
    .done           (done),
    .err            (err),
    .rd_en          (rd_en),
    .rd_addr        (rd_addr),
    .acc_lo_in      (acc_lo_in),
    .acc_lo_neg_in  (acc_lo_neg_in),
    .acc_lo_out     (acc_lo_out),
    .acc_lo_neg_out (acc_lo_neg_out),
    .acc_lo_we      (acc_lo_we)
);

// File: tb/sim_tlu_engine.sv
`timescale 1ns/1ps
module sim_tlu_engine;

    localparam int MEM_WORDS = 2000;
    localparam int AW        = $clog2(MEM_WORDS);
    localparam int LW        = $clog2(MEM_WORDS + 8);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [15:0]       start_addr = '0;
    logic [39:0]       dist_mag = '0;
    logic              even_time = 1'b0;
    logic              rd_en;
    logic [AW-1:0]     rd_addr;
    logic [39:0]       rd_mag;
    logic [39:0]       acc_lo_in = '0;
    logic              acc_lo_neg_in = 1'b0;
    logic [39:0]       acc_lo_out;
    logic              acc_lo_neg_out;
    logic              acc_lo_we;
    logic              busy;
    logic              done;
    logic              err;
    logic [13:0]       entry_count;
    logic [LW-1:0]     exec_len;

    logic [39:0] mem [0:MEM_WORDS-1];

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign rd_mag = (int'(rd_addr) < MEM_WORDS) ? mem[rd_addr] : '0;

    tlu_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .dist_mag(dist_mag), .even_time(even_time), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_mag(rd_mag), .acc_lo_in(acc_lo_in), .acc_lo_neg_in(acc_lo_neg_in),
        .acc_lo_out(acc_lo_out), .acc_lo_neg_out(acc_lo_neg_out), .acc_lo_we(acc_lo_we),
        .busy(busy), .done(done), .err(err), .entry_count(entry_count), .exec_len(exec_len)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint mag(input logic [39:0] w);
        longint v = 0;
        for (int i = 9; i >= 0; i--) v = v * 10 + longint'(w[4*i +: 4]);
        return v;
    endfunction

    function automatic logic [39:0] to_bcd10(input longint v);
        logic [39:0] r;
        for (int i = 0; i < 10; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    function automatic logic [15:0] to_bcd4(input int v);
        logic [15:0] r;
        int t = v % 10000;
        for (int i = 0; i < 4; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic [39:0] rand_bcd();
        logic [39:0] r;
        for (int i = 0; i < 10; i++) r[4*i +: 4] = 4'($urandom % 10);
        return r;
    endfunction

    // bench search model: returns error flag, fills the step count
    function automatic bit model(input int da, input logic [39:0] arg, output int n);
        int a = da - (da % 50);
        n = 0;
        forever begin
            if (a >= MEM_WORDS) return 1'b1;
            if ((a % 50) < 48 && mag(mem[a]) >= mag(arg)) return 1'b0;
            a++;
            n++;
        end
    endfunction

    task automatic search(input int da, input logic [39:0] arg, input bit ev,
                          input logic [39:0] acc, input bit accn, input bit poke,
                          input string tag);
        int  n_exp;
        bit  e_exp;
        int  cyc;
        bit  busy_ok = 1'b1;
        bit  rsv_ok  = 1'b1;
        logic [39:0] acc_exp;
        e_exp = model(da, arg, n_exp);
        acc_exp = acc;
        acc_exp[31:16] = to_bcd4(da + n_exp);

        @(negedge clk);
        start = 1'b1; start_addr = to_bcd4(da); dist_mag = arg;
        even_time = ev; acc_lo_in = acc; acc_lo_neg_in = accn;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            if (!busy) busy_ok = 1'b0;
            if (rd_en && (int'(rd_addr) % 50) >= 48) rsv_ok = 1'b0;
            if (poke && cyc == 3) begin
                start = 1'b1; start_addr = to_bcd4(0);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc < 5000, "R8", {tag, " done seen"}, cyc, 0);
        chk(busy_ok && busy, "R8", {tag, " busy until done"}, busy_ok, 1);
        chk(rsv_ok, "R3", {tag, " no reserved read"}, rsv_ok, 1);
        chk(err == e_exp, "R6", {tag, " err"}, err, e_exp);
        chk(entry_count == 14'(n_exp), "R2", {tag, " entry_count"}, entry_count, n_exp);
        chk(exec_len == LW'(6 + n_exp + int'(ev)), "R7", {tag, " exec_len"},
            exec_len, 6 + n_exp + int'(ev));
        if (e_exp) begin
            chk(acc_lo_we == 1'b0, "R6", {tag, " no write on error"}, acc_lo_we, 0);
        end else begin
            chk(acc_lo_we == 1'b1, "R5", {tag, " write strobe"}, acc_lo_we, 1);
            chk(acc_lo_out == acc_exp, "R5", {tag, " acc word"},
                mag(acc_lo_out), mag(acc_exp));
            chk(acc_lo_neg_out == accn, "R5", {tag, " acc sign"}, acc_lo_neg_out, accn);
        end
        @(negedge clk);
        chk(!done && !busy, "R9", {tag, " done single cycle"}, done, 0);
        chk(entry_count == 14'(n_exp), "R7", {tag, " count held"}, entry_count, n_exp);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd650));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = rand_bcd();

        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !rd_en && !acc_lo_we, "R1", "reset idle",
            {busy, done, err, rd_en, acc_lo_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after release", busy, 0);

        // R2: first word of the band qualifies, result counts from launch address
        mem[1200] = 40'h9999999999;
        search(1234, to_bcd10(123456), 1'b1, 40'h1122334455, 1'b1, 1'b0, "R2 first");

        // R3: reserved words would qualify but are skipped; R8 start ignored while busy
        for (int a = 100; a < 148; a++) mem[a] = '0;
        mem[148] = 40'h9999999999;
        mem[149] = 40'h9999999999;
        mem[150] = to_bcd10(12345);
        search(107, to_bcd10(12345), 1'b0, 40'h9876543210, 1'b0, 1'b1, "R3 skip");

        // R4: lowest digit smaller does not qualify, equal does
        mem[300] = 40'h5555555554;
        mem[301] = 40'h5555555555;
        search(300, 40'h5555555555, 1'b0, '0, 1'b1, 1'b0, "R4 equal");

        // R4: top digit dominates lower digits
        mem[400] = 40'h4999999999;
        mem[401] = 40'h5000000001;
        search(449, 40'h5000000000, 1'b1, 40'h0000000000, 1'b0, 1'b0, "R4 msd");

        // R6: last band holds nothing large enough
        for (int a = 1950; a < 1998; a++) mem[a] = '0;
        search(1960, 40'h0000000001, 1'b1, 40'h1111111111, 1'b0, 1'b0, "R6 end");

        // R6: launch beyond the memory
        search(2150, 40'h0000000001, 1'b0, 40'h1111111111, 1'b1, 1'b0, "R6 beyond");

        // random tables and arguments
        for (int k = 0; k < 30; k++) begin
            logic [39:0] arg;
            arg = rand_bcd();
            arg[39:36] = 4'(7 + ($urandom % 3));
            search(int'($urandom % MEM_WORDS), arg, 1'($urandom), rand_bcd(),
                   1'($urandom), 1'b0, "R4 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule